// File: doc/BRIEF.md
# H-Bridge Motor and Carrier Selector

This block drives the four switch enables of an H-bridge that is shared by a DC motor and a magnetic transmit coil. Two active-low commands choose what the bridge does. Close or open, asserted alone, runs the motor with steady DC in that direction. Both asserted together turn the bridge into an on-off-keyed carrier transmitter. While the serial transmit line is low, the bridge reverses polarity at the carrier rate. While the line idles high, the bridge is dark. A separate request raises the bridge supply to roughly twice its normal level.

An internal divider makes the carrier from the system clock. The default division gives 100 kHz from 125 MHz. Every change of drive passes through a dead-time of at least `DEAD_CYC` cycles with all four switches off. This keeps a high-side and a low-side switch in the same leg from ever conducting together.

All inputs are taken as synchronous to `clk`. There is no data handshake: the serial line is sampled level by level. Every output comes from a register, so a command change shows at the gates one clock later.

Top module: `hbridge_carrier_sel`

## Requirements
- R1: The close drive asserts `gate_hi_left` and `gate_lo_right` with the other two off. The open drive asserts `gate_hi_right` and `gate_lo_left` with the other two off.
- R2: With `close_n` and `open_n` both high, all four gates are off.
- R3: With only `close_n` low, the bridge holds the close drive continuously (steady DC, no carrier reversal).
- R4: With only `open_n` low, the bridge holds the open drive continuously.
- R5: With both commands low and `txd` high, all four gates are off from the cycle after the condition is sampled.
- R6: With both commands low and `txd` low, an internal carrier starts low and toggles every `HALF_CYC` cycles (`HALF_CYC` = CLK_HZ / (2*CARRIER_HZ)). Carrier low requests the close drive and carrier high requests the open drive. The carrier returns to low whenever keying stops.
- R7: While close is the only active command, the open pair is never enabled. The close and open pairs are never enabled in the same cycle.
- R8: `gate_hi_left` and `gate_lo_left` are never both on. `gate_hi_right` and `gate_lo_right` are never both on.
- R9: Between the end of one drive and the start of the other, all gates stay off for exactly `DEAD_CYC`+1 cycles.
- R10: From an all-off settled state, a newly requested drive appears at the gates one clock after the command is sampled.
- R11: `boost_en` equals `dbl_req` as sampled at the previous clock edge.
- R12: While `rst_n` is low, and in the first cycle after reset, all gates and `boost_en` are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_n | input | 1 | Close command, active low |
| open_n | input | 1 | Open command, active low |
| txd | input | 1 | Serial transmit data, idles high |
| dbl_req | input | 1 | Request for the doubled bridge supply |
| gate_hi_left | output | 1 | Upper-left switch enable |
| gate_lo_left | output | 1 | Lower-left switch enable |
| gate_hi_right | output | 1 | Upper-right switch enable |
| gate_lo_right | output | 1 | Lower-right switch enable |
| boost_en | output | 1 | Doubled supply enable |

## Verification
The bench aims at direct reversals between the two motor directions, including reversals from keyed transmission. A design with a wrong or missing dead-time would show the new pair too early, or would briefly enable both switches of one leg. It also covers keying that starts and stops in the middle of a carrier half-period. There, a carrier that is not restarted low would send the wrong polarity first or stretch a phase. Idle-high serial data with both commands low is checked as a dark bridge, which catches a decoder that falls back to close priority there. Phase lengths of exactly `HALF_CYC` minus the gap catch an off-by-one in the divider.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_CLOSE = 2'd1,
    DRV_OPEN  = 2'd2
  } drive_t;
endpackage

// File: rtl/hbc_carrier_gen.sv
module hbc_carrier_gen #(
  parameter int HALF_CYC = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic carrier
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt     <= '0;
      carrier <= 1'b0;
    end else if (cnt == LAST) begin
      cnt     <= '0;
      carrier <= ~carrier;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbc_dir_select.sv
module hbc_dir_select
  import hbc_pkg::*;
(
  input  logic   close_n,
  input  logic   open_n,
  input  logic   txd,
  input  logic   carrier,
  output logic   keying,
  output drive_t target
);
  logic both;
  assign both   = !close_n && !open_n;
  assign keying = both && !txd;

  always_comb begin
    if (both) begin
      if (txd)          target = DRV_OFF;
      else if (carrier) target = DRV_OPEN;
      else              target = DRV_CLOSE;
    end else if (!close_n) begin
      target = DRV_CLOSE;
    end else if (!open_n) begin
      target = DRV_OPEN;
    end else begin
      target = DRV_OFF;
    end
  end
endmodule

// File: rtl/hbc_deadtime.sv
module hbc_deadtime
  import hbc_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  drive_t target,
  output drive_t applied
);
  localparam int DW = $clog2(DEAD_CYC + 1) + 1;
  localparam logic [DW-1:0] DLOAD = DW'(DEAD_CYC);

  logic [DW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      applied <= DRV_OFF;
      gap     <= '0;
    end else if (target != applied) begin
      if (applied != DRV_OFF) begin
        applied <= DRV_OFF;
        gap     <= DLOAD;
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end else begin
        applied <= target;
      end
    end else if (gap != '0) begin
      gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/hbc_gate_decode.sv
module hbc_gate_decode
  import hbc_pkg::*;
(
  input  drive_t applied,
  output logic   hi_left,
  output logic   lo_left,
  output logic   hi_right,
  output logic   lo_right
);
  logic pair_c, pair_o;
  assign pair_c   = (applied == DRV_CLOSE);
  assign pair_o   = (applied == DRV_OPEN);
  assign hi_left  = pair_c;
  assign lo_right = pair_c;
  assign hi_right = pair_o;
  assign lo_left  = pair_o;
endmodule

// File: rtl/hbridge_carrier_sel.sv
module hbridge_carrier_sel
  import hbc_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int CARRIER_HZ = 100_000,
  parameter int DEAD_CYC   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic close_n,
  input  logic open_n,
  input  logic txd,
  input  logic dbl_req,
  output logic gate_hi_left,
  output logic gate_lo_left,
  output logic gate_hi_right,
  output logic gate_lo_right,
  output logic boost_en
);
  localparam int HALF_CYC = CLK_HZ / (2 * CARRIER_HZ);

  logic   keying, carrier;
  drive_t target, applied;

  hbc_carrier_gen #(.HALF_CYC(HALF_CYC)) u_car (
    .clk(clk), .rst_n(rst_n), .run(keying), .carrier(carrier)
  );

  hbc_dir_select u_sel (
    .close_n(close_n), .open_n(open_n), .txd(txd), .carrier(carrier),
    .keying(keying), .target(target)
  );

  hbc_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_n), .target(target), .applied(applied)
  );

  hbc_gate_decode u_dec (
    .applied(applied),
    .hi_left(gate_hi_left), .lo_left(gate_lo_left),
    .hi_right(gate_hi_right), .lo_right(gate_lo_right)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) boost_en <= 1'b0;
    else        boost_en <= dbl_req;
  end
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
  parameter int DEAD_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic close_n,
  input logic open_n,
  input logic txd,
  input logic dbl_req,
  input logic gate_hi_left,
  input logic gate_lo_left,
  input logic gate_hi_right,
  input logic gate_lo_right,
  input logic boost_en
);
  logic close_on, open_on, all_off;
  assign close_on = gate_hi_left && gate_lo_right;
  assign open_on  = gate_hi_right && gate_lo_left;
  assign all_off  = !gate_hi_left && !gate_lo_left && !gate_hi_right && !gate_lo_right;

  logic [15:0] off_run;
  logic [1:0]  last_dir;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_run  <= '0;
      last_dir <= 2'd0;
    end else begin
      off_run <= all_off ? ((off_run == 16'hFFFF) ? off_run : off_run + 1'b1) : '0;
      if (close_on)     last_dir <= 2'd1;
      else if (open_on) last_dir <= 2'd2;
    end
  end

  a_r8_left_leg: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_left && gate_lo_left));
  a_r8_right_leg: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_right && gate_lo_right));
  a_r7_pairs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({close_on, open_on}));
  a_r7_close_blocks_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_n && open_n) |=> !open_on);
  a_r5_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_n && !open_n && txd) |=> all_off);
  a_r2_no_cmd_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (close_n && open_n) |=> all_off);
  a_r9_gap_to_close: assert property (@(posedge clk) disable iff (!rst_n)
    (close_on && last_dir == 2'd2) |-> (off_run >= 16'(DEAD_CYC + 1)));
  a_r9_gap_to_open: assert property (@(posedge clk) disable iff (!rst_n)
    (open_on && last_dir == 2'd1) |-> (off_run >= 16'(DEAD_CYC + 1)));
  a_r11_boost_on: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_req |=> boost_en);
  a_r11_boost_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_req |=> !boost_en);
endmodule

bind hbridge_carrier_sel hbc_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .close_n(close_n), .open_n(open_n), .txd(txd),
  .dbl_req(dbl_req), .gate_hi_left(gate_hi_left), .gate_lo_left(gate_lo_left),
  .gate_hi_right(gate_hi_right), .gate_lo_right(gate_lo_right),
  .boost_en(boost_en)
);

// File: tb/hbridge_carrier_sel_test.sv
module hbridge_carrier_sel_test;
  localparam int HALF = 625;
  localparam int DEAD = 4;
  localparam logic [3:0] G_OFF = 4'b0000, G_CLOSE = 4'b1001, G_OPEN = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0;
  logic close_n = 1'b1, open_n = 1'b1, txd = 1'b1, dbl_req = 1'b0;
  logic g_hl, g_ll, g_hr, g_lr, boost;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hbridge_carrier_sel uut (
    .clk(clk), .rst_n(rst_n), .close_n(close_n), .open_n(open_n), .txd(txd),
    .dbl_req(dbl_req), .gate_hi_left(g_hl), .gate_lo_left(g_ll),
    .gate_hi_right(g_hr), .gate_lo_right(g_lr), .boost_en(boost)
  );

  // gate vector order: {hi_left, lo_left, hi_right, lo_right}
  logic [3:0] gv;
  assign gv = {g_hl, g_ll, g_hr, g_lr};

  // behavioural reference: 0 off, 1 close, 2 open
  int m_app = 0, m_gap = 0, m_ccnt = 0;
  bit m_car = 0, m_boost = 0;

  always @(posedge clk) begin
    int tgt;
    bit both, key;
    if (!rst_n) begin
      m_app = 0; m_gap = 0; m_ccnt = 0; m_car = 0; m_boost = 0;
    end else begin
      both = !close_n && !open_n;
      key  = both && !txd;
      if (both) tgt = txd ? 0 : (m_car ? 2 : 1);
      else if (!close_n) tgt = 1;
      else if (!open_n) tgt = 2;
      else tgt = 0;
      if (tgt != m_app) begin
        if (m_app != 0) begin m_app = 0; m_gap = DEAD; end
        else if (m_gap > 0) m_gap = m_gap - 1;
        else m_app = tgt;
      end else if (m_gap > 0) m_gap = m_gap - 1;
      if (!key) begin m_ccnt = 0; m_car = 0; end
      else if (m_ccnt == HALF - 1) begin m_ccnt = 0; m_car = !m_car; end
      else m_ccnt = m_ccnt + 1;
      m_boost = dbl_req;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e;
      string r;
      e = (m_app == 1) ? G_CLOSE : (m_app == 2) ? G_OPEN : G_OFF;
      if (!close_n && !open_n) r = txd ? "R5" : "R6";
      else if (!close_n) r = "R3";
      else if (!open_n) r = "R4";
      else r = "R2";
      chk(r, gv, e);
      chk("R11", {3'b0, boost}, {3'b0, m_boost});
      chk("R8", {2'b0, g_hl & g_ll, g_hr & g_lr}, 4'b0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cnt;
    step(3);
    chk("R12", {gv[3:1], boost}, 4'b0);
    chk("R12", gv, G_OFF);
    rst_n = 1'b1;
    step(1);
    chk("R12", gv, G_OFF);
    // R10 latency and R1 close pair
    close_n = 1'b0; dbl_req = 1'b1;
    step(1);
    chk("R10", gv, G_CLOSE);
    chk("R1", gv, G_CLOSE);
    chk("R11", {3'b0, boost}, 4'b0001);
    step(200);
    chk("R3", gv, G_CLOSE);
    // direct reversal to open, measure gap (R9)
    close_n = 1'b1; open_n = 1'b0; dbl_req = 1'b0;
    cnt = 0;
    step(1);
    while (gv == G_OFF && cnt < 50) begin cnt++; step(1); end
    chk("R9", 4'(cnt), 4'(DEAD + 1));
    chk("R1", gv, G_OPEN);
    chk("R11", {3'b0, boost}, 4'b0);
    step(100);
    chk("R4", gv, G_OPEN);
    // reversal back to close
    open_n = 1'b1; close_n = 1'b0;
    cnt = 0;
    step(1);
    while (gv == G_OFF && cnt < 50) begin cnt++; step(1); end
    chk("R9", 4'(cnt), 4'(DEAD + 1));
    chk("R7", gv, G_CLOSE);
    // both low, idle high: dark
    open_n = 1'b0; txd = 1'b1;
    step(30);
    chk("R5", gv, G_OFF);
    // keyed carrier
    txd = 1'b0;
    step(1);
    chk("R6", gv, G_CLOSE);
    cnt = 0;
    while (gv != G_OPEN && cnt < 5000) step(1);
    while (gv != G_CLOSE && cnt < 5000) step(1);
    cnt = 0;
    while (gv == G_CLOSE && cnt < 5000) begin cnt++; step(1); end
    chk("R6", 4'((cnt == HALF - DEAD - 1) ? 1 : 0), 4'd1);
    step(HALF * 3 + 17);
    // stop keying mid-phase, restart: carrier restarts low
    txd = 1'b1;
    step(20);
    chk("R5", gv, G_OFF);
    txd = 1'b0;
    step(1);
    chk("R6", gv, G_CLOSE);
    step(HALF + 300);
    // release both commands from keying
    close_n = 1'b1; open_n = 1'b1;
    step(2);
    chk("R2", gv, G_OFF);
    // open while keying open phase then to open-only
    open_n = 1'b0;
    step(300);
    dbl_req = 1'b1;
    step(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule